// File: doc/BRIEF.md
# Link/Accumulator Operate Unit

This block carries out the register-only "operate" class of a 12-bit accumulator machine. The machine keeps a single link bit beside the accumulator. The two together form a 13-bit value with the link as its most significant bit. One operate word may ask for several micro-operations at once. The unit applies them in a fixed order. It returns the new link and accumulator, a skip flag that tells the sequencer to step the program counter one extra word, and a halt flag.

Each request is presented for one cycle on `valid_i`, together with the operate word, the current link and accumulator, and the front-panel switch value. The result is registered and appears one cycle later with `valid_o` high. Operate words come in two groups, selected by bit 8. Group A clears, complements, increments and rotates. Group B holds the skip tests, the switch merge and halt. Both groups can clear the accumulator, and the clear is applied before everything else in the word.

Top module: `lac_operate_unit`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, skip_o and halt_o are low, and link_o and ac_o are zero, until the first accepted request.
- R2: A request with valid_i high produces its result on the next rising edge with valid_o high. A cycle with valid_i low leaves valid_o low on the next edge.
- R3: In both groups, op bit 7 clears the accumulator. In group A (op bit 8 = 0), op bit 6 clears the link. Clears are applied first.
- R4: In group A, op bit 5 complements the accumulator and op bit 4 complements the link. Complements are applied after the clears, so clear plus complement yields all ones.
- R5: In group A, op bit 0 adds one to the 13-bit link:accumulator value after the complements. A carry out of the accumulator toggles the link.
- R6: In group A, after the increment, op bit 3 rotates link:accumulator right through the link and op bit 2 rotates it left. The move is one position, or two when op bit 1 is also set. With both bits 3 and 2 set, no rotation takes place.
- R7: In group A, op bit 1 with neither direction bit set exchanges the upper and lower 6-bit halves of the accumulator and leaves the link unchanged.
- R8: In group B (op bit 8 = 1) with op bit 3 clear, the skip flag is the OR of the selected tests. The tests are: bit 6, accumulator negative (accumulator bit 11 set); bit 5, accumulator zero; bit 4, link set.
- R9: In group B with op bit 3 set, the skip flag is the AND of the inverses of the selected tests. With no test selected, the skip is unconditional.
- R10: Group B skip tests see the accumulator as it stands after a bit-7 clear in the same word.
- R11: In group B, op bit 2 ORs switch_i into the accumulator after the clear, so clear plus merge loads the switches. The link passes through unchanged in group B.
- R12: In group B, op bit 1 raises halt_o for that result.
- R13: A group A word never raises skip_o or halt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 9 | Operate word; bit 8 selects the group |
| link_i | input | 1 | Current link bit |
| ac_i | input | 12 | Current accumulator |
| switch_i | input | 12 | Switch register value |
| valid_o | output | 1 | Result valid |
| link_o | output | 1 | New link bit |
| ac_o | output | 12 | New accumulator |
| skip_o | output | 1 | Skip the next word |
| halt_o | output | 1 | Stop the processor |

## Verification
A clear and a skip test can fall in the same group B word. The skip must then judge the cleared accumulator, not the incoming one. The bench provokes this with words that combine the clear with the zero test and with the negative test, in both senses, on nonzero negative accumulators. It compares skip_o against a model that clears first. In group A the same overlap exists between complement, increment and rotate, and these are judged the same way: an all-ones accumulator is incremented and rotated in one word.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int unsigned OP_W = 9;
  localparam int unsigned GRP_BIT = 8;

  typedef struct packed {
    logic grp_b;
    logic clr_ac;
    logic clr_lnk;
    logic cpl_ac;
    logic cpl_lnk;
    logic inc;
    logic rot_r;
    logic rot_l;
    logic twice;
    logic t_neg;
    logic t_zero;
    logic t_lnk;
    logic inv;
    logic or_sw;
    logic halt;
  } opu_ctl_t;
endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output opu_ctl_t        ctl_o
);
  logic grp_b;
  assign grp_b = op_i[GRP_BIT];

  always_comb begin
    ctl_o         = '0;
    ctl_o.grp_b   = grp_b;
    ctl_o.clr_ac  = op_i[7];
    if (!grp_b) begin
      ctl_o.clr_lnk = op_i[6];
      ctl_o.cpl_ac  = op_i[5];
      ctl_o.cpl_lnk = op_i[4];
      ctl_o.rot_r   = op_i[3];
      ctl_o.rot_l   = op_i[2];
      ctl_o.twice   = op_i[1];
      ctl_o.inc     = op_i[0];
    end else begin
      ctl_o.t_neg   = op_i[6];
      ctl_o.t_zero  = op_i[5];
      ctl_o.t_lnk   = op_i[4];
      ctl_o.inv     = op_i[3];
      ctl_o.or_sw   = op_i[2];
      ctl_o.halt    = op_i[1];
    end
  end
endmodule

// File: rtl/opu_arith.sv
// Clear -> complement -> increment on the link:accumulator pair.
module opu_arith #(
  parameter int unsigned AC_W = 12
) (
  input  logic            clr_ac_i,
  input  logic            clr_lnk_i,
  input  logic            cpl_ac_i,
  input  logic            cpl_lnk_i,
  input  logic            inc_i,
  input  logic            link_i,
  input  logic [AC_W-1:0] ac_i,
  output logic [AC_W:0]   la_o
);
  localparam int unsigned LA_W = AC_W + 1;

  logic [AC_W-1:0] ac_c, ac_x;
  logic            l_c, l_x;
  logic [LA_W-1:0] la_x;

  always_comb begin
    ac_c = clr_ac_i  ? '0 : ac_i;
    l_c  = clr_lnk_i ? 1'b0 : link_i;
    ac_x = cpl_ac_i  ? ~ac_c : ac_c;
    l_x  = cpl_lnk_i ? ~l_c : l_c;
    la_x = {l_x, ac_x};
    la_o = inc_i ? la_x + LA_W'(1) : la_x;
  end
endmodule

// File: rtl/opu_shift.sv
// Final stage of group A: rotate by one or two, or half swap.
module opu_shift #(
  parameter int unsigned AC_W = 12
) (
  input  logic          rot_r_i,
  input  logic          rot_l_i,
  input  logic          twice_i,
  input  logic [AC_W:0] la_i,
  output logic [AC_W:0] la_o
);
  localparam int unsigned LA_W = AC_W + 1;
  localparam int unsigned HALF = AC_W / 2;

  logic [LA_W-1:0] r1, r2, l1, l2, sw;

  assign r1 = {la_i[0], la_i[LA_W-1:1]};
  assign r2 = {la_i[1:0], la_i[LA_W-1:2]};
  assign l1 = {la_i[LA_W-2:0], la_i[LA_W-1]};
  assign l2 = {la_i[LA_W-3:0], la_i[LA_W-1:LA_W-2]};

  generate
    if (AC_W % 2 == 0) begin : g_swap
      assign sw = {la_i[AC_W], la_i[HALF-1:0], la_i[AC_W-1:HALF]};
    end else begin : g_noswap
      assign sw = la_i;
    end
  endgenerate

  always_comb begin
    unique case ({rot_r_i, rot_l_i})
      2'b10:   la_o = twice_i ? r2 : r1;
      2'b01:   la_o = twice_i ? l2 : l1;
      2'b00:   la_o = twice_i ? sw : la_i;
      default: la_o = la_i;
    endcase
  end
endmodule

// File: rtl/opu_skip.sv
module opu_skip #(
  parameter int unsigned AC_W = 12
) (
  input  logic            t_neg_i,
  input  logic            t_zero_i,
  input  logic            t_lnk_i,
  input  logic            inv_i,
  input  logic            link_i,
  input  logic [AC_W-1:0] ac_i,
  output logic            skip_o
);
  logic any_hit;
  assign any_hit = (t_neg_i & ac_i[AC_W-1]) | (t_zero_i & (ac_i == '0)) | (t_lnk_i & link_i);
  // Inverse sense: AND of negated tests == NOT of the OR.
  assign skip_o = any_hit ^ inv_i;
endmodule

// File: rtl/lac_operate_unit.sv
module lac_operate_unit
  import opu_pkg::*;
#(
  parameter int unsigned AC_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            link_i,
  input  logic [AC_W-1:0] ac_i,
  input  logic [AC_W-1:0] switch_i,
  output logic            valid_o,
  output logic            link_o,
  output logic [AC_W-1:0] ac_o,
  output logic            skip_o,
  output logic            halt_o
);
  localparam int unsigned HALF = AC_W / 2;

  opu_ctl_t        ctl;
  logic [AC_W:0]   la_arith, la_shift;
  logic [AC_W-1:0] ac_b_clr, ac_b;
  logic            skip_b;
  logic            n_link, n_skip, n_halt;
  logic [AC_W-1:0] n_ac;

  opu_decode u_decode (.op_i(op_i), .ctl_o(ctl));

  opu_arith #(.AC_W(AC_W)) u_arith (
    .clr_ac_i (ctl.clr_ac),
    .clr_lnk_i(ctl.clr_lnk),
    .cpl_ac_i (ctl.cpl_ac),
    .cpl_lnk_i(ctl.cpl_lnk),
    .inc_i    (ctl.inc),
    .link_i   (link_i),
    .ac_i     (ac_i),
    .la_o     (la_arith)
  );

  opu_shift #(.AC_W(AC_W)) u_shift (
    .rot_r_i(ctl.rot_r),
    .rot_l_i(ctl.rot_l),
    .twice_i(ctl.twice),
    .la_i   (la_arith),
    .la_o   (la_shift)
  );

  // Group B: clear precedes both the tests and the switch merge.
  assign ac_b_clr = ctl.clr_ac ? '0 : ac_i;
  assign ac_b     = ctl.or_sw ? (ac_b_clr | switch_i) : ac_b_clr;

  opu_skip #(.AC_W(AC_W)) u_skip (
    .t_neg_i (ctl.t_neg),
    .t_zero_i(ctl.t_zero),
    .t_lnk_i (ctl.t_lnk),
    .inv_i   (ctl.inv),
    .link_i  (link_i),
    .ac_i    (ac_b_clr),
    .skip_o  (skip_b)
  );

  always_comb begin
    if (ctl.grp_b) begin
      n_link = link_i;
      n_ac   = ac_b;
      n_skip = skip_b;
      n_halt = ctl.halt;
    end else begin
      n_link = la_shift[AC_W];
      n_ac   = la_shift[AC_W-1:0];
      n_skip = 1'b0;
      n_halt = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      link_o  <= 1'b0;
      ac_o    <= '0;
      skip_o  <= 1'b0;
      halt_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        link_o <= n_link;
        ac_o   <= n_ac;
        skip_o <= n_skip;
        halt_o <= n_halt;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r13_grp_a_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[GRP_BIT]) |=> (!skip_o && !halt_o));
  a_r7_half_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_W'('b0_0000_0010)) |=>
      (ac_o == {$past(ac_i[HALF-1:0]), $past(ac_i[AC_W-1:HALF])} && link_o == $past(link_i)));
  a_r9_empty_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[GRP_BIT] && op_i[3] && op_i[6:4] == 3'b000) |=> skip_o);
  a_r10_zero_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[GRP_BIT] && op_i[7] && op_i[5] && !op_i[3]) |=> skip_o);
  a_r12_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[GRP_BIT] && op_i[1]) |=> halt_o);
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_W'('b0_0000_0001) && ac_i == '1) |=>
      (ac_o == '0 && link_o == !$past(link_i)));
endmodule

// File: tb/lac_operate_unit_bench.sv
module lac_operate_unit_bench;
  localparam int AC_W = 12;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [8:0]      op_i = '0;
  logic            link_i = 1'b0;
  logic [AC_W-1:0] ac_i = '0;
  logic [AC_W-1:0] switch_i = '0;
  logic            valid_o, link_o, skip_o, halt_o;
  logic [AC_W-1:0] ac_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  lac_operate_unit #(.AC_W(AC_W)) u_lac_operate_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .link_i(link_i), .ac_i(ac_i), .switch_i(switch_i), .valid_o(valid_o),
    .link_o(link_o), .ac_o(ac_o), .skip_o(skip_o), .halt_o(halt_o)
  );

  // Expected {skip, halt, link, ac} from the requirement text.
  function automatic logic [14:0] model(logic [8:0] op, logic l, logic [11:0] ac, logic [11:0] sw);
    logic [12:0] la;
    logic sk, hl, hit;
    sk = 1'b0; hl = 1'b0;
    if (!op[8]) begin
      if (op[7]) ac = '0;
      if (op[6]) l = 1'b0;
      if (op[5]) ac = ~ac;
      if (op[4]) l = ~l;
      la = {l, ac};
      if (op[0]) la = la + 13'd1;
      if (op[3] && !op[2]) la = op[1] ? {la[1:0], la[12:2]} : {la[0], la[12:1]};
      else if (op[2] && !op[3]) la = op[1] ? {la[10:0], la[12:11]} : {la[11:0], la[12]};
      else if (!op[3] && !op[2] && op[1]) la = {la[12], la[5:0], la[11:6]};
      l = la[12]; ac = la[11:0];
    end else begin
      if (op[7]) ac = '0;
      hit = (op[6] && ac[11]) || (op[5] && ac == 0) || (op[4] && l);
      sk = op[3] ? !hit : hit;
      if (op[2]) ac = ac | sw;
      hl = op[1];
    end
    return {sk, hl, l, ac};
  endfunction

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [8:0] op, logic l, logic [11:0] ac, logic [11:0] sw, string tag);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; link_i = l; ac_i = ac; switch_i = sw;
    exp_q.push_back(model(op, l, ac, sw));
    tag_q.push_back(tag);
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: actual unexpected result expected none");
      end else begin
        check(tag_q.pop_front(), {skip_o, halt_o, link_o, ac_o}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", {valid_o, skip_o, halt_o, link_o, ac_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {valid_o, skip_o, halt_o, link_o, ac_o}, '0);

    // R3 / R4 clears and complements
    drive(9'b0_1100_0000, 1'b1, 12'hABC, '0, "R3 clear both");
    drive(9'b0_1010_0000, 1'b0, 12'h123, '0, "R4 clear then complement");
    drive(9'b0_0101_0000, 1'b1, 12'h0F0, '0, "R4 clear link then complement");
    // R5 increment
    drive(9'b0_0000_0001, 1'b0, 12'hFFF, '0, "R5 carry into link");
    drive(9'b0_0000_0001, 1'b1, 12'hFFF, '0, "R5 carry wraps");
    drive(9'b0_0010_0001, 1'b0, 12'h000, '0, "R5 complement then increment");
    // R6 rotates
    drive(9'b0_0000_1000, 1'b1, 12'h801, '0, "R6 right one");
    drive(9'b0_0000_1010, 1'b0, 12'h003, '0, "R6 right two");
    drive(9'b0_0000_0100, 1'b1, 12'h800, '0, "R6 left one");
    drive(9'b0_0000_0110, 1'b0, 12'hC00, '0, "R6 left two");
    drive(9'b0_0000_1100, 1'b1, 12'h5A5, '0, "R6 both directions");
    drive(9'b0_0000_1001, 1'b0, 12'hFFF, '0, "R6 increment then rotate");
    // R7 swap
    drive(9'b0_0000_0010, 1'b1, 12'hA3C, '0, "R7 half swap");
    // R8 normal skips
    drive(9'b1_0100_0000, 1'b0, 12'h800, '0, "R8 negative");
    drive(9'b1_0010_0000, 1'b0, 12'h001, '0, "R8 zero miss");
    drive(9'b1_0111_0000, 1'b1, 12'h001, '0, "R8 or of tests");
    // R9 inverted
    drive(9'b1_0000_1000, 1'b1, 12'h800, '0, "R9 empty inverted");
    drive(9'b1_0110_1000, 1'b0, 12'h001, '0, "R9 and of inverses hit");
    drive(9'b1_0110_1000, 1'b0, 12'h000, '0, "R9 and of inverses miss");
    drive(9'b1_0001_1000, 1'b1, 12'h001, '0, "R9 link zero miss");
    // R10 tests after clear
    drive(9'b1_1010_0000, 1'b0, 12'h800, '0, "R10 clear then zero");
    drive(9'b1_1100_0000, 1'b0, 12'h800, '0, "R10 clear then negative");
    drive(9'b1_1100_1000, 1'b0, 12'hFFF, '0, "R10 clear then nonneg");
    // R11 switches
    drive(9'b1_1000_0100, 1'b1, 12'h0F0, 12'h321, "R11 load switches");
    drive(9'b1_0000_0100, 1'b0, 12'h0F0, 12'h00F, "R11 or switches");
    // R12 halt, R13 group A quiet
    drive(9'b1_0000_0010, 1'b0, 12'h555, '0, "R12 halt");
    drive(9'b0_1111_1111, 1'b1, 12'h777, '0, "R13 group A all bits");
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R2 idle", {31'd0, valid_o}, {31'd0, 1'b0});

    for (int i = 0; i < 300; i++) begin
      drive(9'($urandom), 1'($urandom), 12'($urandom), 12'($urandom), "R2 mixed");
      if (i % 7 == 0) begin
        @(negedge clk_i);
        valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R2 drained", {17'd0, 15'(exp_q.size())}, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule